// File: doc/BRIEF.md
# Nested exception fault escalator

This block sits beside a processor core's exception entry logic. Each time the core raises an exception vector, the block decides what to deliver: the vector unchanged, a double fault (vector 8), or nothing at all, in which case it requests a shutdown. It decides by comparing the class of the new vector with the class of the last relevant vector it has remembered.

Vectors fall into three groups. The contributory group is the divide error (0) and vectors 10 to 13. The page fault is vector 14. Every other vector is benign. Vector 8 is treated on its own as the double fault.

A clear strobe tells the block that a handler has been entered successfully, and the block then forgets the remembered vector. A raise flagged as a software interrupt is delivered as it is and never takes part in the nesting check. Once a shutdown has been requested, the block stays silent until it is reset.

Top module: `fault_esc_top`

## Requirements
- R1: After reset, all outputs are 0 and no vector is remembered, so the first checked raise after reset is delivered unchanged.
- R2: A contributory vector (0, or 10 to 13 inclusive) raised while the remembered vector is contributory is delivered as vector 8 with error code 0.
- R3: A contributory vector or vector 14 raised while the remembered vector is 14 is delivered as vector 8 with error code 0.
- R4: Any checked raise (software-interrupt flag 0) while the remembered vector is 8 produces no delivery and a shutdown_o pulse exactly one cycle wide. After that, no input causes any delivery or any further pulse until reset.
- R5: The remembered vector takes the delivered vector only when that vector is contributory, 14 or 8. A delivered benign vector, such as 3, leaves it unchanged.
- R6: A raise with swint_i=1 is delivered with its own vector and error code, even when the remembered vector is 8, and it leaves the remembered vector unchanged.
- R7: A clear_i strobe without a raise returns the remembered vector to the empty state, so a following contributory raise is delivered unchanged.
- R8: A raise is answered in the next cycle: deliv_valid_o is high for exactly one cycle, and a delivery that is not escalated carries the raised vector and error code unchanged. This includes a direct raise of vector 8 that follows a contributory vector.
- R9: Vector 14 raised while the remembered vector is contributory is delivered unchanged as 14, and 14 becomes the remembered vector.
- R10: When raise_i and clear_i are high in the same cycle, the raise is judged against the remembered vector as it stood before the clear. Afterwards the remembered vector is the one the raise stores under R5, or empty if the raise stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| raise_i | input | 1 | One-cycle strobe: a new exception is raised |
| vec_i | input | 8 | Vector of the raised exception |
| err_i | input | 32 | Error code of the raised exception |
| swint_i | input | 1 | The raise comes from a software interrupt instruction |
| clear_i | input | 1 | A handler was entered successfully; forget the remembered vector |
| deliv_valid_o | output | 1 | A final vector is presented this cycle |
| deliv_vec_o | output | 8 | Final vector to deliver |
| deliv_err_o | output | 32 | Final error code to deliver |
| shutdown_o | output | 1 | One-cycle shutdown request (triple fault) |

## Verification
Every result, whether a delivery, a shutdown pulse or an empty cycle, is due in the cycle after the raise was sampled, because a single output register stage sits between the inputs and the ports. The driver changes inputs on the falling edge and pushes one expected item per cycle, including empty items for cycles that must stay silent. The monitor pops and compares a quarter period after each rising edge, so each check lands exactly one register stage after its stimulus. The expected items come from a model of the remembered vector written directly from the requirements. Held-off behaviour after a shutdown and the same-cycle clear case are therefore checked at the ports, cycle by cycle.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;

  typedef enum logic [1:0] {
    CLS_BENIGN  = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2,
    CLS_DOUBLE  = 2'd3
  } vec_class_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_PASS     = 2'd1,
    ACT_ESCALATE = 2'd2,
    ACT_SHUTDOWN = 2'd3
  } esc_action_e;

endpackage

// File: rtl/fault_esc_classify.sv
module fault_esc_classify
  import fault_esc_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int DE_VEC  = 0,
  parameter int CON_LO  = 10,
  parameter int CON_HI  = 13,
  parameter int PF_VEC  = 14,
  parameter int DF_VEC  = 8
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic             present_i,
  output vec_class_e       cls_o
);

  localparam logic [VEC_W-1:0] DE_V = VEC_W'(DE_VEC);
  localparam logic [VEC_W-1:0] LO_V = VEC_W'(CON_LO);
  localparam logic [VEC_W-1:0] HI_V = VEC_W'(CON_HI);
  localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  logic in_range;
  logic is_contrib;

  always_comb begin
    in_range   = (vec_i >= LO_V) && (vec_i <= HI_V);
    is_contrib = in_range || (vec_i == DE_V);
    if (!present_i) begin
      cls_o = CLS_BENIGN;
    end else if (is_contrib) begin
      cls_o = CLS_CONTRIB;
    end else if (vec_i == PF_V) begin
      cls_o = CLS_PAGE;
    end else if (vec_i == DF_V) begin
      cls_o = CLS_DOUBLE;
    end else begin
      cls_o = CLS_BENIGN;
    end
  end

endmodule

// File: rtl/fault_esc_decide.sv
module fault_esc_decide
  import fault_esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int DF_VEC = 8
) (
  input  logic             raise_i,
  input  logic             swint_i,
  input  logic             halted_i,
  input  vec_class_e       prior_cls_i,
  input  vec_class_e       new_cls_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  output esc_action_e      act_o,
  output logic [VEC_W-1:0] out_vec_o,
  output logic [ERR_W-1:0] out_err_o,
  output logic             upd_en_o,
  output logic [VEC_W-1:0] upd_vec_o
);

  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  logic pair_cc;
  logic pair_pf;
  logic checked;

  always_comb begin
    checked = raise_i && !halted_i && !swint_i;
    pair_cc = (prior_cls_i == CLS_CONTRIB) && (new_cls_i == CLS_CONTRIB);
    pair_pf = (prior_cls_i == CLS_PAGE) &&
              ((new_cls_i == CLS_CONTRIB) || (new_cls_i == CLS_PAGE));

    act_o = ACT_NONE;
    if (raise_i && !halted_i) begin
      if (swint_i) begin
        act_o = ACT_PASS;
      end else if (prior_cls_i == CLS_DOUBLE) begin
        act_o = ACT_SHUTDOWN;
      end else if (pair_cc || pair_pf) begin
        act_o = ACT_ESCALATE;
      end else begin
        act_o = ACT_PASS;
      end
    end

    if (act_o == ACT_ESCALATE) begin
      out_vec_o = DF_V;
      out_err_o = '0;
    end else begin
      out_vec_o = vec_i;
      out_err_o = err_i;
    end

    upd_vec_o = out_vec_o;
    upd_en_o  = checked &&
                ((act_o == ACT_ESCALATE) ||
                 ((act_o == ACT_PASS) && (new_cls_i != CLS_BENIGN)));
  end

endmodule

// File: rtl/fault_esc_state.sv
module fault_esc_state
  import fault_esc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  esc_action_e      act_i,
  input  logic             upd_en_i,
  input  logic [VEC_W-1:0] upd_vec_i,
  input  logic             clear_i,
  output logic             prior_valid_o,
  output logic [VEC_W-1:0] prior_vec_o,
  output logic             halted_o
);

  logic             valid_q, valid_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             halted_q, halted_d;
  logic             prior_en;
  logic             halt_en;

  always_comb begin
    valid_d  = valid_q;
    vec_d    = vec_q;
    halted_d = halted_q;
    prior_en = 1'b0;
    halt_en  = 1'b0;
    if (act_i == ACT_SHUTDOWN) begin
      valid_d  = 1'b0;
      halted_d = 1'b1;
      prior_en = 1'b1;
      halt_en  = 1'b1;
    end else if (upd_en_i) begin
      valid_d  = 1'b1;
      vec_d    = upd_vec_i;
      prior_en = 1'b1;
    end else if (clear_i && !halted_q) begin
      valid_d  = 1'b0;
      prior_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (prior_en) begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
    end else if (halt_en) begin
      halted_q <= halted_d;
    end
  end

  assign prior_valid_o = valid_q;
  assign prior_vec_o   = vec_q;
  assign halted_o      = halted_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R4

  AST_HALT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> !valid_q); // R4

  AST_BENIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en_i && !clear_i && act_i != ACT_SHUTDOWN) |=> $stable(vec_q) && $stable(valid_q)); // R5

endmodule

// File: rtl/fault_esc_top.sv
module fault_esc_top
  import fault_esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int DE_VEC = 0,
  parameter int CON_LO = 10,
  parameter int CON_HI = 13,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             swint_i,
  input  logic             clear_i,
  output logic             deliv_valid_o,
  output logic [VEC_W-1:0] deliv_vec_o,
  output logic [ERR_W-1:0] deliv_err_o,
  output logic             shutdown_o
);

  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  // reset synchronizer: asserts at once, releases on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  vec_class_e       prior_cls, new_cls;
  esc_action_e      act;
  logic [VEC_W-1:0] dec_vec, upd_vec, prior_vec;
  logic [ERR_W-1:0] dec_err;
  logic             upd_en, prior_valid, halted;

  fault_esc_classify #(
    .VEC_W(VEC_W), .DE_VEC(DE_VEC), .CON_LO(CON_LO), .CON_HI(CON_HI),
    .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)
  ) u_cls_prior (
    .vec_i(prior_vec), .present_i(prior_valid), .cls_o(prior_cls)
  );

  fault_esc_classify #(
    .VEC_W(VEC_W), .DE_VEC(DE_VEC), .CON_LO(CON_LO), .CON_HI(CON_HI),
    .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)
  ) u_cls_new (
    .vec_i(vec_i), .present_i(1'b1), .cls_o(new_cls)
  );

  fault_esc_decide #(
    .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)
  ) u_decide (
    .raise_i(raise_i), .swint_i(swint_i), .halted_i(halted),
    .prior_cls_i(prior_cls), .new_cls_i(new_cls),
    .vec_i(vec_i), .err_i(err_i),
    .act_o(act), .out_vec_o(dec_vec), .out_err_o(dec_err),
    .upd_en_o(upd_en), .upd_vec_o(upd_vec)
  );

  fault_esc_state #(
    .VEC_W(VEC_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n_s), .act_i(act), .upd_en_i(upd_en),
    .upd_vec_i(upd_vec), .clear_i(clear_i),
    .prior_valid_o(prior_valid), .prior_vec_o(prior_vec), .halted_o(halted)
  );

  // output register stage
  logic             valid_d, shut_d, data_en;
  logic             valid_q, shut_q;
  logic [VEC_W-1:0] vec_q;
  logic [ERR_W-1:0] err_q;

  always_comb begin
    valid_d = (act == ACT_PASS) || (act == ACT_ESCALATE);
    shut_d  = (act == ACT_SHUTDOWN);
    data_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      shut_q  <= shut_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vec_q <= '0;
      err_q <= '0;
    end else if (data_en) begin
      vec_q <= dec_vec;
      err_q <= dec_err;
    end
  end

  assign deliv_valid_o = valid_q;
  assign deliv_vec_o   = vec_q;
  assign deliv_err_o   = err_q;
  assign shutdown_o    = shut_q;

  AST_SHUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    shutdown_o |=> !shutdown_o); // R4

  AST_SILENT_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n_s)
    halted |=> !deliv_valid_o && !shutdown_o); // R4

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(deliv_valid_o && shutdown_o)); // R4

  AST_CC_TO_DF: assert property (@(posedge clk) disable iff (!rst_n_s)
    (raise_i && !swint_i && !halted && prior_cls == CLS_CONTRIB && new_cls == CLS_CONTRIB)
    |=> deliv_valid_o && deliv_vec_o == DF_V && deliv_err_o == '0); // R2

  AST_SWINT_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (raise_i && swint_i && !halted)
    |=> deliv_valid_o && deliv_vec_o == $past(vec_i) && deliv_err_o == $past(err_i)); // R6

  AST_NO_RAISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !raise_i |=> !deliv_valid_o && !shutdown_o); // R8

endmodule

// File: tb/fault_esc_top_test.sv
module fault_esc_top_test;

  typedef struct {
    logic        valid;
    logic        shut;
    logic [7:0]  vec;
    logic [31:0] err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_i, swint_i, clear_i;
  logic [7:0]  vec_i;
  logic [31:0] err_i;
  logic        deliv_valid_o, shutdown_o;
  logic [7:0]  deliv_vec_o;
  logic [31:0] deliv_err_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t q[$];
  logic mon_en = 1'b0;

  // model of the remembered vector, -1 means empty
  int   m_prior;
  logic m_halted;

  always #10 clk = ~clk;

  fault_esc_top uut (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .vec_i(vec_i), .err_i(err_i),
    .swint_i(swint_i), .clear_i(clear_i), .deliv_valid_o(deliv_valid_o),
    .deliv_vec_o(deliv_vec_o), .deliv_err_o(deliv_err_o), .shutdown_o(shutdown_o)
  );

  function automatic logic is_con(int v);
    return (v == 0) || (v >= 10 && v <= 13);
  endfunction

  task automatic step(input logic r, input int v, input int e, input logic sw,
                      input logic cl, input string tag);
    exp_t x;
    @(negedge clk);
    raise_i = r; vec_i = v[7:0]; err_i = e; swint_i = sw; clear_i = cl;
    x.valid = 1'b0; x.shut = 1'b0; x.vec = 8'd0; x.err = 32'd0; x.tag = tag;
    if (r && !m_halted) begin
      if (sw) begin
        x.valid = 1'b1; x.vec = v[7:0]; x.err = e;
      end else if (m_prior == 8) begin
        x.shut = 1'b1; m_halted = 1'b1; m_prior = -1;
      end else begin
        x.valid = 1'b1;
        if ((is_con(m_prior) && m_prior >= 0 && is_con(v)) ||
            (m_prior == 14 && (is_con(v) || v == 14))) begin
          x.vec = 8'd8; x.err = 32'd0;
        end else begin
          x.vec = v[7:0]; x.err = e;
        end
        if (is_con(int'(x.vec)) || x.vec == 8'd14 || x.vec == 8'd8)
          m_prior = int'(x.vec);
        else if (cl)
          m_prior = -1;
      end
    end else if (cl && !m_halted) begin
      m_prior = -1;
    end
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #5;
    if (mon_en && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_tests++;
      if (deliv_valid_o !== x.valid || shutdown_o !== x.shut ||
          (x.valid && (deliv_vec_o !== x.vec || deliv_err_o !== x.err))) begin
        n_fail++;
        $display("FAIL %s: got valid=%0b shut=%0b vec=%0d err=%0h, expected valid=%0b shut=%0b vec=%0d err=%0h",
                 x.tag, deliv_valid_o, shutdown_o, deliv_vec_o, deliv_err_o,
                 x.valid, x.shut, x.vec, x.err);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst_n = 1'b0;
    raise_i = 0; swint_i = 0; clear_i = 0; vec_i = 0; err_i = 0;
    m_prior = -1; m_halted = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (deliv_valid_o !== 1'b0 || shutdown_o !== 1'b0 ||
        deliv_vec_o !== 8'd0 || deliv_err_o !== 32'd0) begin
      n_fail++;
      $display("FAIL R1: reset outputs valid=%0b shut=%0b vec=%0d err=%0h, expected all 0",
               deliv_valid_o, shutdown_o, deliv_vec_o, deliv_err_o);
    end
    mon_en = 1'b1;
  endtask

  task automatic drain();
    step(0, 0, 0, 0, 0, "R8 idle");
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    step(1, 10, 32'h5, 0, 0, "R1 first raise unchanged");
    step(1, 13, 32'h7, 0, 0, "R2 contrib after contrib");
    step(0, 0, 0, 0, 1, "R7 clear");
    step(1, 0, 32'h3, 0, 0, "R7 contrib after clear");
    step(1, 14, 32'h9, 0, 0, "R9 page after contrib");
    step(1, 3, 32'h1, 0, 0, "R5 benign keeps prior");
    step(1, 14, 32'h2, 0, 0, "R3 page after page");
    step(0, 0, 0, 0, 0, "R8 gap");
    step(1, 1, 32'h4, 0, 0, "R4 shutdown on prior double");
    step(0, 0, 0, 0, 0, "R4 pulse ends");
    step(1, 10, 32'h6, 0, 0, "R4 held after shutdown");
    step(0, 0, 0, 0, 1, "R4 clear held");
    step(1, 14, 32'h8, 1, 0, "R4 swint held");
    step(1, 14, 32'h8, 0, 0, "R4 still held");
    drain();

    do_reset();
    step(1, 14, 32'h11, 0, 0, "R8 page fault err passes");
    step(1, 13, 32'h6, 1, 0, "R6 swint bypass");
    step(1, 11, 32'h22, 0, 0, "R6 prior unchanged by swint, R3");
    step(1, 5, 32'h33, 1, 0, "R6 swint with prior double");
    step(1, 8, 32'h44, 0, 0, "R4 direct double after double");
    drain();

    do_reset();
    step(1, 11, 32'h10, 0, 1, "R10 raise with clear stores");
    step(1, 12, 32'h20, 0, 0, "R10 prior kept, R2");
    step(0, 0, 0, 0, 1, "R7 clear");
    step(1, 14, 32'h30, 0, 0, "R9 page first");
    step(1, 6, 32'h40, 0, 1, "R10 benign raise with clear");
    step(1, 12, 32'h50, 0, 0, "R10 prior emptied");
    step(1, 8, 32'h55, 0, 0, "R8 direct double keeps err");
    step(1, 14, 32'h66, 0, 0, "R4 shutdown after direct double");
    step(0, 0, 0, 0, 0, "R4 single pulse");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule